// File: doc/BRIEF.md
# Spare-Word Memory Repair Wrapper

This block sits beside an embedded SRAM and hides faulty words behind a small bank of spare word registers. While the memory self-test runs, every failure pulse from the test engine writes the failing address and the data the engine expected into a spare entry. From then on any functional access whose address hits a stored entry is served by that entry: reads return the spare data in the same cycle as the array read, and writes land in the spare entry while the array write strobe is held off.

When more distinct addresses fail than there are spare entries, a sticky overflow flag marks the part as not repairable. The stored valid bits and addresses form a serial shift chain. After test they are shifted out so that fuses can be programmed. At power-up the fuse values are shifted back in through the same chain to rebuild the repair map. The data fields are not part of the chain. They are filled by ordinary writes.

Top module: `spare_word_repair`

## Requirements
- R1: After reset every entry is invalid and `overflow` is 0, so every read misses (`hit` = 0) and `rd_data` equals `arr_rdata`.
- R2: A `bist_fail` pulse for an address held by no valid entry, while an entry is free, fills the lowest-indexed invalid entry with that address and `bist_exp`. From the next cycle a read of that address returns that data.
- R3: A `bist_fail` pulse for an address already held by a valid entry overwrites that entry's data and leaves every other entry free.
- R4: A `bist_fail` pulse for a new address while all entries are valid sets `overflow` and changes no entry. `overflow` stays 1 until reset.
- R5: Reads are combinational. When `acc_addr` matches a valid entry, `hit` is 1 and `rd_data` is that entry's data in the same cycle. Otherwise `hit` is 0 and `rd_data` equals `arr_rdata`.
- R6: A write (`acc_en` and `acc_we`) to a matching address updates the spare data and holds `arr_we` at 0. A write to any other address drives `arr_we` to 1.
- R7: While `scan_en` is 1 the chain of valid and address bits shifts by one bit per clock, taking `scan_in` at its tail. `scan_out` presents the chain head. The order from head to tail is: the highest entry first, within each entry the valid bit and then the address from MSB to LSB, then the next lower entry. The data fields are kept.
- R8: While `scan_en` is 1, `bist_fail` is ignored: no entry is filled and `overflow` does not change.
- R9: A failure on an address that is already stored does not set `overflow`, even when all entries are valid.
- R10: When a failure and a functional write target the same stored entry in one cycle, the failure's expected data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bist_fail | input | 1 | Failure pulse from the test engine; acts as the capture strobe |
| bist_addr | input | ADDR_W | Address that failed |
| bist_exp | input | DATA_W | Data the test engine expected at that address |
| acc_en | input | 1 | Functional access valid |
| acc_we | input | 1 | Functional access is a write |
| acc_addr | input | ADDR_W | Functional access address |
| acc_wdata | input | DATA_W | Functional write data |
| arr_rdata | input | DATA_W | Read data from the SRAM array |
| arr_we | output | 1 | Write strobe to the SRAM array, suppressed on a spare hit |
| rd_data | output | DATA_W | Read data after spare substitution |
| hit | output | 1 | Access address matches a valid spare entry |
| overflow | output | 1 | Sticky flag: more failing addresses than spare entries |
| scan_en | input | 1 | Shift the repair chain |
| scan_in | input | 1 | Serial input at the chain tail |
| scan_out | output | 1 | Serial output at the chain head |

## Verification
On every cycle the assertions check four things: a failure taken with no overflow makes that address hit with the expected data on the next cycle, `overflow` only rises on a failure outside scan and never falls, a scan cycle leaves `overflow` unchanged, and the array write strobe is raised only by a functional write. Some behaviour can only be shown by the bench's scenarios. These are the choice of the lowest free entry, updating an existing entry in place so that a later fourth address still fits, the write-versus-failure collision, and the exact serial bit order of a full unload and reload of the chain.

// File: rtl/repair_pkg.sv
package repair_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE,
        CAP_UPDATE,
        CAP_ALLOC,
        CAP_OVERFLOW
    } cap_e;
endpackage

// File: rtl/repair_match.sv
// Parallel compare of one key against every valid spare entry.
module repair_match #(
    parameter int N_SPARE = 4,
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16
) (
    input  logic [N_SPARE-1:0]        vld,
    input  logic [N_SPARE*ADDR_W-1:0] adr,
    input  logic [N_SPARE*DATA_W-1:0] dat,
    input  logic [ADDR_W-1:0]         key,
    output logic                      any_hit,
    output logic [N_SPARE-1:0]        hit_oh,
    output logic [DATA_W-1:0]         hit_data
);
    for (genvar g = 0; g < N_SPARE; g++) begin : g_cmp
        assign hit_oh[g] = vld[g] && (adr[g*ADDR_W +: ADDR_W] == key);
    end

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < N_SPARE; i++) begin
            if (hit_oh[i]) hit_data = hit_data | dat[i*DATA_W +: DATA_W];
        end
    end

    assign any_hit = |hit_oh;
endmodule

// File: rtl/repair_free_pick.sv
// Finds the lowest-indexed invalid entry.
module repair_free_pick #(
    parameter int N_SPARE = 4
) (
    input  logic [N_SPARE-1:0] vld,
    output logic               any_free,
    output logic [N_SPARE-1:0] pick_oh
);
    always_comb begin
        logic found;
        found   = 1'b0;
        pick_oh = '0;
        for (int i = 0; i < N_SPARE; i++) begin
            if (!vld[i] && !found) begin
                pick_oh[i] = 1'b1;
                found      = 1'b1;
            end
        end
    end

    assign any_free = ~&vld;
endmodule

// File: rtl/spare_word_repair.sv
module spare_word_repair #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int N_SPARE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bist_fail,
    input  logic [ADDR_W-1:0] bist_addr,
    input  logic [DATA_W-1:0] bist_exp,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_we,
    output logic [DATA_W-1:0] rd_data,
    output logic              hit,
    output logic              overflow,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out
);
    import repair_pkg::*;

    localparam int SLICE_W = ADDR_W + 1;
    localparam int CHAIN_W = N_SPARE * SLICE_W;

    typedef struct packed {
        logic [N_SPARE-1:0]             vld;
        logic [N_SPARE-1:0][ADDR_W-1:0] adr;
        logic [N_SPARE-1:0][DATA_W-1:0] dat;
        logic                           ovf;
    } state_t;

    state_t s_q, s_d;

    logic               acc_hit, fail_hit, any_free;
    logic [N_SPARE-1:0] acc_oh, fail_oh, pick_oh;
    logic [DATA_W-1:0]  acc_data, fail_data_unused;
    logic [CHAIN_W-1:0] chain_q;
    cap_e               cap;

    repair_match #(.N_SPARE(N_SPARE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc_match (
        .vld(s_q.vld), .adr(s_q.adr), .dat(s_q.dat), .key(acc_addr),
        .any_hit(acc_hit), .hit_oh(acc_oh), .hit_data(acc_data)
    );

    repair_match #(.N_SPARE(N_SPARE), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fail_match (
        .vld(s_q.vld), .adr(s_q.adr), .dat(s_q.dat), .key(bist_addr),
        .any_hit(fail_hit), .hit_oh(fail_oh), .hit_data(fail_data_unused)
    );

    repair_free_pick #(.N_SPARE(N_SPARE)) u_pick (
        .vld(s_q.vld), .any_free(any_free), .pick_oh(pick_oh)
    );

    // Chain view: highest entry at the head, valid bit above its address.
    always_comb begin
        for (int i = 0; i < N_SPARE; i++) begin
            chain_q[i*SLICE_W +: SLICE_W] = {s_q.vld[i], s_q.adr[i]};
        end
    end

    always_comb begin
        logic [CHAIN_W-1:0] chain_d;
        s_d     = s_q;
        cap     = CAP_IDLE;
        chain_d = '0;
        if (scan_en) begin
            chain_d = {chain_q[CHAIN_W-2:0], scan_in};
            for (int i = 0; i < N_SPARE; i++) begin
                {s_d.vld[i], s_d.adr[i]} = chain_d[i*SLICE_W +: SLICE_W];
            end
        end else begin
            if (acc_en && acc_we && acc_hit) begin
                for (int i = 0; i < N_SPARE; i++) begin
                    if (acc_oh[i]) s_d.dat[i] = acc_wdata;
                end
            end
            if (bist_fail) begin
                if (fail_hit)      cap = CAP_UPDATE;
                else if (any_free) cap = CAP_ALLOC;
                else               cap = CAP_OVERFLOW;
            end
            case (cap)
                CAP_UPDATE: begin
                    for (int i = 0; i < N_SPARE; i++) begin
                        if (fail_oh[i]) s_d.dat[i] = bist_exp;
                    end
                end
                CAP_ALLOC: begin
                    for (int i = 0; i < N_SPARE; i++) begin
                        if (pick_oh[i]) begin
                            s_d.vld[i] = 1'b1;
                            s_d.adr[i] = bist_addr;
                            s_d.dat[i] = bist_exp;
                        end
                    end
                end
                CAP_OVERFLOW: s_d.ovf = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign hit      = acc_hit;
    assign rd_data  = acc_hit ? acc_data : arr_rdata;
    assign arr_we   = acc_en && acc_we && !acc_hit;
    assign overflow = s_q.ovf;
    assign scan_out = chain_q[CHAIN_W-1];
endmodule

// File: rtl/repair_checker.sv
module repair_checker #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int N_SPARE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bist_fail,
    input logic [ADDR_W-1:0] bist_addr,
    input logic [DATA_W-1:0] bist_exp,
    input logic              acc_en,
    input logic              acc_we,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic [DATA_W-1:0] arr_rdata,
    input logic              arr_we,
    input logic [DATA_W-1:0] rd_data,
    input logic              hit,
    input logic              overflow,
    input logic              scan_en,
    input logic              scan_in,
    input logic              scan_out
);
    AST_CAPTURE_SERVES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bist_fail && !scan_en && !overflow) && !overflow && acc_addr == $past(bist_addr))
        |-> (hit && rd_data == $past(bist_exp))); // R2
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow); // R4
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(bist_fail && !scan_en)); // R4
    AST_SCAN_KEEPS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        scan_en |=> $stable(overflow)); // R8
    AST_ARR_WE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (acc_en && acc_we)); // R6
endmodule

bind spare_word_repair repair_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SPARE(N_SPARE)
) u_repair_checker (.*);

// File: tb/test_spare_word_repair.sv
module test_spare_word_repair;
    localparam int AW = 8;
    localparam int DW = 16;
    localparam int NS = 4;
    localparam int CW = NS * (AW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bist_fail = 1'b0;
    logic [AW-1:0] bist_addr = '0;
    logic [DW-1:0] bist_exp = '0;
    logic          acc_en = 1'b0;
    logic          acc_we = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [DW-1:0] acc_wdata = '0;
    logic [DW-1:0] arr_rdata = '0;
    logic          arr_we;
    logic [DW-1:0] rd_data;
    logic          hit;
    logic          overflow;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spare_word_repair #(.ADDR_W(AW), .DATA_W(DW), .N_SPARE(NS)) i_spare_word_repair (.*);

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_fail(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bist_fail = 1'b1; bist_addr = a; bist_exp = d;
        @(posedge clk);
        @(negedge clk);
        bist_fail = 1'b0;
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit exp_we, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
        #1 chk(arr_we == exp_we, req, arr_we, exp_we);
        @(posedge clk);
        @(negedge clk);
        acc_en = 1'b0; acc_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [DW-1:0] arr, input bit exp_hit,
                          input logic [DW-1:0] exp_d, input string req);
        @(negedge clk);
        acc_en = 1'b1; acc_we = 1'b0; acc_addr = a; arr_rdata = arr;
        #1;
        chk(hit == exp_hit, {req, " hit"}, hit, exp_hit);
        chk(rd_data == exp_d, {req, " data"}, rd_data, exp_d);
        acc_en = 1'b0;
    endtask

    task automatic t_reset();
        chk(overflow == 1'b0, "R1 overflow", overflow, 0);
        rd_chk(8'h12, 16'h0BAD, 1'b0, 16'h0BAD, "R1 empty map");
    endtask

    task automatic t_capture();
        do_fail(8'h12, 16'hAAAA);
        rd_chk(8'h12, 16'h0000, 1'b1, 16'hAAAA, "R2 capture");
        rd_chk(8'h13, 16'h1313, 1'b0, 16'h1313, "R5 miss passes array");
    endtask

    task automatic t_update_then_fill();
        do_fail(8'h12, 16'hBBBB);
        rd_chk(8'h12, 16'h0000, 1'b1, 16'hBBBB, "R3 update data");
        do_fail(8'h20, 16'h2020);
        do_fail(8'h30, 16'h3030);
        do_fail(8'h40, 16'h4040);
        chk(overflow == 1'b0, "R3 update kept entry free", overflow, 0);
        rd_chk(8'h40, 16'h0000, 1'b1, 16'h4040, "R2 fourth entry");
    endtask

    task automatic t_write();
        do_write(8'h20, 16'hC0C0, 1'b0, "R6 hit blocks array write");
        rd_chk(8'h20, 16'h0000, 1'b1, 16'hC0C0, "R6 spare written");
        do_write(8'h55, 16'h5555, 1'b1, "R6 miss writes array");
    endtask

    task automatic t_collide();
        @(negedge clk);
        bist_fail = 1'b1; bist_addr = 8'h30; bist_exp = 16'hD0D0;
        acc_en = 1'b1; acc_we = 1'b1; acc_addr = 8'h30; acc_wdata = 16'hE0E0;
        @(posedge clk);
        @(negedge clk);
        bist_fail = 1'b0; acc_en = 1'b0; acc_we = 1'b0;
        rd_chk(8'h30, 16'h0000, 1'b1, 16'hD0D0, "R10 fail wins");
    endtask

    task automatic t_full_update();
        do_fail(8'h40, 16'hF0F0);
        chk(overflow == 1'b0, "R9 no overflow on known addr", overflow, 0);
        rd_chk(8'h40, 16'h0000, 1'b1, 16'hF0F0, "R9 data updated");
    endtask

    task automatic t_overflow();
        do_fail(8'h77, 16'h7777);
        chk(overflow == 1'b1, "R4 overflow set", overflow, 1);
        rd_chk(8'h77, 16'h0707, 1'b0, 16'h0707, "R4 no entry taken");
        rd_chk(8'h12, 16'h0000, 1'b1, 16'hBBBB, "R4 entries unchanged");
        do_fail(8'h12, 16'h6666);
        chk(overflow == 1'b1, "R4 overflow sticky", overflow, 1);
    endtask

    task automatic t_scan();
        logic [CW-1:0] exp_out;
        logic [CW-1:0] load;
        int mism;
        exp_out = {1'b1, 8'h40, 1'b1, 8'h30, 1'b1, 8'h20, 1'b1, 8'h12};
        load    = {1'b0, 8'h00, 1'b1, 8'h5A, 1'b0, 8'hFF, 1'b1, 8'h01};
        mism = 0;
        @(negedge clk);
        scan_en = 1'b1;
        bist_fail = 1'b1; bist_addr = 8'h99; bist_exp = 16'h9999;
        for (int i = CW - 1; i >= 0; i--) begin
            scan_in = load[i];
            #1;
            if (scan_out !== exp_out[i]) mism++;
            @(negedge clk);
        end
        scan_en = 1'b0; bist_fail = 1'b0;
        chk(mism == 0, "R7 unload order", mism, 0);
        chk(overflow == 1'b1, "R8 overflow kept in scan", overflow, 1);
        rd_chk(8'h99, 16'h0909, 1'b0, 16'h0909, "R8 fail ignored in scan");
        rd_chk(8'h5A, 16'h0000, 1'b1, 16'hD0D0, "R7 loaded entry keeps data");
        rd_chk(8'h01, 16'h0000, 1'b1, 16'h6666, "R7 loaded entry 0");
        rd_chk(8'hFF, 16'h0F0F, 1'b0, 16'h0F0F, "R7 loaded invalid");
        rd_chk(8'h40, 16'h0404, 1'b0, 16'h0404, "R7 old map replaced");
    endtask

    task automatic t_rereset();
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(overflow == 1'b0, "R1 overflow after reset", overflow, 0);
        rd_chk(8'h5A, 16'h1234, 1'b0, 16'h1234, "R1 map cleared");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_capture();
        t_update_then_fill();
        t_write();
        t_collide();
        t_full_update();
        t_overflow();
        t_scan();
        t_rereset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule